// File: doc/BRIEF.md
# MSI Event Queue Controller

The block collects message-signalled interrupt data words into one circular queue per interrupt group. A write-side event port delivers a 32-bit word together with a group number. If that group's queue is enabled and has room, the word goes into the internal queue RAM at the group's tail index, and the tail advances on the same clock edge. Hardware owns the tail. Software owns the head: it reads queued words through a read port, and after consuming them it writes the head register forward.

Each group drives a level-sensitive interrupt line. The line is high while its queue holds unconsumed words and every enable that applies to that group is set. A queue holds one slot fewer than its depth, so head equal to tail always means empty. A word that arrives for a queue that is already at that limit is dropped, and a sticky per-group overflow flag is set.

Top module: `msi_evq`

## Requirements
- R1: After reset, every head, tail, control, overflow and global-enable register reads zero, and every interrupt line is low.
- R2: A word sent to a group whose queue-enable (control bit 0) is clear is discarded. That group's tail does not move and its overflow flag stays as it was.
- R3: A word accepted for group g is stored at entry tail(g), and tail(g) increases by one on the same edge.
- R4: The entry port returns the word at (group, index) one cycle after the read strobe.
- R5: Interrupt g is registered. One cycle after the state changes, it equals the condition head(g) != tail(g) with all enables set.
- R6: The control register keeps only bit 0 (queue enable), bit 1 (interrupt on event) and bit 11 (interrupt enable). All three must be set for the interrupt to fire, and the other bits read back as zero.
- R7: Bit g of the global-enable register (register 4, the group field is ignored) must also be set for interrupt g to fire.
- R8: When a queue already holds 63 words, an incoming word for it is dropped, the tail stays unchanged, and overflow flag g (bit 0 of register 3) is set.
- R9: The overflow flag stays set until software writes a 1 to bit 0 of register 3. Writing 0 leaves it set.
- R10: Head and tail wrap modulo 64. A head write keeps only the low 6 bits of the written value.
- R11: When a word and a head write for the same group arrive in the same cycle, fullness is judged against the head value from before that write.
- R12: Register reads return their data one cycle after the read strobe. The map is: 0 control, 1 head, 2 tail (read-only), 3 status, 4 global enable. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Incoming event word strobe |
| ev_grp | input | 3 | Target group of the event |
| ev_data | input | 32 | Event data word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_grp | input | 3 | Group select for register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| q_rd_en | input | 1 | Queue entry read strobe |
| q_rd_grp | input | 3 | Group of the entry read |
| q_rd_idx | input | 6 | Entry index within the queue |
| q_rd_data | output | 32 | Registered entry data |
| irq_o | output | 6 | Per-group interrupt lines |

## Verification
The risky overlap is an incoming word and a software head update for the same group in the same cycle. The tail must advance, or the word must be dropped, according to the head value from before the update, while the head still takes its new value. The bench fills a queue to 63 words and then issues a word and a head write together. It expects the word to be lost, the overflow flag to be set and the head to move. During random traffic, pushes and head writes also collide freely, and the reference model applies the same ordering rule.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;
  localparam int REG_W   = 32;
  localparam int CTL_QEN = 0;
  localparam int CTL_EVT = 1;
  localparam int CTL_IEN = 11;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_HEAD = 3'd1,
    RA_TAIL = 3'd2,
    RA_STAT = 3'd3,
    RA_GEN  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/msi_evq_ram.sv
module msi_evq_ram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/msi_evq_grp.sv
module msi_evq_grp
  import msi_evq_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             ctrl_we,
  input  logic             head_we,
  input  logic             stat_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             gen_bit,
  output logic             accept,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] tail_q,
  output logic [2:0]       ctrl_q,
  output logic             ovf_q,
  output logic             irq_q
);
  logic [PTR_W-1:0] used;
  logic             full;

  assign used   = tail_q - head_q;
  assign full   = (used == {PTR_W{1'b1}});
  assign accept = push & ctrl_q[0] & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (accept)  tail_q <= tail_q + 1'b1;
      if (head_we) head_q <= wdata[PTR_W-1:0];
      if (ctrl_we) ctrl_q <= {wdata[CTL_IEN], wdata[CTL_EVT], wdata[CTL_QEN]};
      if (push & ctrl_q[0] & full)  ovf_q <= 1'b1;
      else if (stat_we & wdata[0])  ovf_q <= 1'b0;
      irq_q <= (&ctrl_q) & gen_bit & (head_q != tail_q);
    end
  end
endmodule

// File: rtl/msi_evq.sv
module msi_evq
  import msi_evq_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter int PTR_W   = 6,
  parameter int DATA_W  = 32,
  parameter bit HAS_GEN = 1'b1,
  localparam int GW     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [GW-1:0]     ev_grp,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [GW-1:0]     reg_grp,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              q_rd_en,
  input  logic [GW-1:0]     q_rd_grp,
  input  logic [PTR_W-1:0]  q_rd_idx,
  output logic [DATA_W-1:0] q_rd_data,
  output logic [NUM_GRP-1:0] irq_o
);
  localparam int AW = GW + PTR_W;

  logic [NUM_GRP-1:0][PTR_W-1:0] head_all;
  logic [NUM_GRP-1:0][PTR_W-1:0] tail_all;
  logic [NUM_GRP-1:0][2:0]       ctrl_all;
  logic [NUM_GRP-1:0]            ovf_all;
  logic [NUM_GRP-1:0]            acc_all;
  logic [NUM_GRP-1:0]            qen_all;
  logic [NUM_GRP-1:0]            gen_q;

  generate
    if (HAS_GEN) begin : g_gen
      logic [NUM_GRP-1:0] gen_r;
      always_ff @(posedge clk) begin
        if (rst) gen_r <= '0;
        else if (reg_wr && reg_addr == RA_GEN) gen_r <= reg_wdata[NUM_GRP-1:0];
      end
      assign gen_q = gen_r;
    end else begin : g_nogen
      assign gen_q = '1;
    end
  endgenerate

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic sel;
    assign sel = (reg_grp == GW'(g));
    msi_evq_grp #(.PTR_W(PTR_W)) u_grp (
      .clk     (clk),
      .rst     (rst),
      .push    (ev_valid && ev_grp == GW'(g)),
      .ctrl_we (reg_wr && sel && reg_addr == RA_CTRL),
      .head_we (reg_wr && sel && reg_addr == RA_HEAD),
      .stat_we (reg_wr && sel && reg_addr == RA_STAT),
      .wdata   (reg_wdata),
      .gen_bit (gen_q[g]),
      .accept  (acc_all[g]),
      .head_q  (head_all[g]),
      .tail_q  (tail_all[g]),
      .ctrl_q  (ctrl_all[g]),
      .ovf_q   (ovf_all[g]),
      .irq_q   (irq_o[g])
    );
    assign qen_all[g] = ctrl_all[g][0];
  end

  // Write address: tail of the event's group
  logic [PTR_W-1:0] ev_tail;
  always_comb begin
    ev_tail = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (ev_grp == GW'(g)) ev_tail = tail_all[g];
  end

  msi_evq_ram #(.AW(AW), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (|acc_all),
    .waddr ({ev_grp, ev_tail}),
    .wdata (ev_data),
    .re    (q_rd_en),
    .raddr ({q_rd_grp, q_rd_idx}),
    .rdata (q_rd_data)
  );

  // Register read path
  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_grp == GW'(g)) begin
        case (reg_addr)
          RA_CTRL: begin
            rd_mux[CTL_QEN] = ctrl_all[g][0];
            rd_mux[CTL_EVT] = ctrl_all[g][1];
            rd_mux[CTL_IEN] = ctrl_all[g][2];
          end
          RA_HEAD: rd_mux[PTR_W-1:0] = head_all[g];
          RA_TAIL: rd_mux[PTR_W-1:0] = tail_all[g];
          RA_STAT: rd_mux[0] = ovf_all[g];
          default: ;
        endcase
      end
    end
    if (reg_addr == RA_GEN && HAS_GEN) rd_mux[NUM_GRP-1:0] = gen_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/msi_evq_chk.sv
module msi_evq_chk #(
  parameter int NUM_GRP = 6,
  parameter int PTR_W   = 6,
  parameter int GW      = 3
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          ev_valid,
  input logic [GW-1:0]                 ev_grp,
  input logic [NUM_GRP-1:0]            irq_o,
  input logic [NUM_GRP-1:0][PTR_W-1:0] head_all,
  input logic [NUM_GRP-1:0][PTR_W-1:0] tail_all,
  input logic [NUM_GRP-1:0]            qen_all
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_d) reset_irq_chk: assert (irq_o == '0);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    // R3
    tail_step_chk: assert property (@(posedge clk) disable iff (rst)
      (tail_all[g] != $past(tail_all[g])) |-> (tail_all[g] == PTR_W'($past(tail_all[g]) + 1)));

    // R2
    drop_off_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_grp == GW'(g) && !qen_all[g]) |=> $stable(tail_all[g]));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_grp == GW'(g) && PTR_W'(tail_all[g] - head_all[g]) == {PTR_W{1'b1}})
      |=> $stable(tail_all[g]));

    // R5
    irq_pending_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o[g] |-> $past(head_all[g] != tail_all[g]));
  end
endmodule

bind msi_evq msi_evq_chk #(.NUM_GRP(NUM_GRP), .PTR_W(PTR_W), .GW(GW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_valid (ev_valid),
  .ev_grp   (ev_grp),
  .irq_o    (irq_o),
  .head_all (head_all),
  .tail_all (tail_all),
  .qen_all  (qen_all)
);

// File: tb/msi_evq_tb.sv
module msi_evq_tb;
  localparam int NG = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        ev_valid;
  logic [2:0]  ev_grp;
  logic [31:0] ev_data;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [2:0]  reg_grp;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        q_rd_en;
  logic [2:0]  q_rd_grp;
  logic [5:0]  q_rd_idx;
  logic [31:0] q_rd_data;
  logic [NG-1:0] irq_o;

  always #4 clk = ~clk;

  msi_evq u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_grp(ev_grp), .ev_data(ev_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_grp(reg_grp),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .q_rd_en(q_rd_en),
    .q_rd_grp(q_rd_grp), .q_rd_idx(q_rd_idx), .q_rd_data(q_rd_data), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  int          m_head [NG];
  int          m_tail [NG];
  int          m_ctrl [NG];
  bit          m_ovf  [NG];
  int          m_gen;
  int unsigned m_mem  [NG][64];

  function automatic int used(int g);
    return (m_tail[g] - m_head[g]) & 63;
  endfunction

  function automatic logic [NG-1:0] exp_irq();
    logic [NG-1:0] v;
    for (int g = 0; g < NG; g++)
      v[g] = (m_ctrl[g] == 32'h803) && m_gen[g] && (m_head[g] != m_tail[g]);
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_in();
    ev_valid = 0; ev_grp = 0; ev_data = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_grp = 0; reg_wdata = 0;
    q_rd_en = 0; q_rd_grp = 0; q_rd_idx = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk); clr_in(); tick();
  endtask

  // push, optionally with a same-cycle head write to the same group
  task automatic push(int g, int unsigned d, bit hw = 0, int hv = 0);
    @(negedge clk); clr_in();
    ev_valid = 1; ev_grp = 3'(g); ev_data = d;
    if (hw) begin reg_wr = 1; reg_addr = 3'd1; reg_grp = 3'(g); reg_wdata = hv; end
    if (m_ctrl[g] & 1) begin
      if (used(g) == 63) m_ovf[g] = 1;
      else begin m_mem[g][m_tail[g]] = d; m_tail[g] = (m_tail[g] + 1) & 63; end
    end
    if (hw) m_head[g] = hv & 63;
    tick();
  endtask

  task automatic wreg(int a, int g, int unsigned d);
    @(negedge clk); clr_in();
    reg_wr = 1; reg_addr = 3'(a); reg_grp = 3'(g); reg_wdata = d;
    case (a)
      0: m_ctrl[g] = d & 32'h803;
      1: m_head[g] = d & 63;
      3: if (d & 1) m_ovf[g] = 0;
      4: m_gen = d & 6'h3f;
      default: ;
    endcase
    tick();
  endtask

  task automatic chk_reg(int a, int g, string tag);
    logic [31:0] e;
    @(negedge clk); clr_in();
    reg_rd = 1; reg_addr = 3'(a); reg_grp = 3'(g);
    case (a)
      0: e = m_ctrl[g];
      1: e = m_head[g];
      2: e = m_tail[g];
      3: e = {31'd0, m_ovf[g]};
      4: e = m_gen;
      default: e = 0;
    endcase
    tick();
    check(tag, reg_rdata, e);
  endtask

  task automatic chk_ent(int g, int i, string tag);
    @(negedge clk); clr_in();
    q_rd_en = 1; q_rd_grp = 3'(g); q_rd_idx = 6'(i);
    tick();
    check(tag, q_rd_data, m_mem[g][i & 63]);
  endtask

  task automatic chk_irq(string tag);
    idle();
    check(tag, {26'd0, irq_o}, {26'd0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int g = 0; g < NG; g++) begin
      m_head[g] = 0; m_tail[g] = 0; m_ctrl[g] = 0; m_ovf[g] = 0;
      for (int i = 0; i < 64; i++) m_mem[g][i] = 0;
    end
    m_gen = 0;
    clr_in();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq at reset", {26'd0, irq_o}, 32'd0);
    @(negedge clk); rst = 0;

    // R1 register reset values
    for (int g = 0; g < NG; g++) begin
      chk_reg(0, g, "R1 ctrl"); chk_reg(1, g, "R1 head");
      chk_reg(2, g, "R1 tail"); chk_reg(3, g, "R1 stat");
    end
    chk_reg(4, 0, "R1 gen");
    chk_reg(7, 0, "R12 unmapped");

    // R2 disabled queue drops words
    push(0, 32'hdead_0001);
    chk_reg(2, 0, "R2 tail unchanged");
    chk_reg(3, 0, "R2 no overflow");

    // R3 R4 R5 accepted words
    wreg(4, 0, 32'h3f);
    wreg(0, 0, 32'hffff_ffff);
    chk_reg(0, 0, "R6 ctrl readback masked");
    for (int i = 0; i < 3; i++) push(0, 32'h1000_0000 + i);
    chk_reg(2, 0, "R3 tail after 3");
    for (int i = 0; i < 3; i++) chk_ent(0, i, "R4 entry data");
    chk_irq("R5 irq with pending");
    wreg(0, 0, 32'h801);
    chk_irq("R6 irq needs event bit");
    wreg(0, 0, 32'h803);
    wreg(4, 0, 32'h3e);
    chk_irq("R7 global enable gates irq");
    wreg(4, 0, 32'h3f);
    chk_irq("R7 global enable restored");
    wreg(1, 0, 3);
    chk_irq("R5 irq drops when head==tail");

    // R8 R9 full queue
    wreg(0, 1, 32'h803);
    for (int i = 0; i < 63; i++) push(1, 32'h2000_0000 + i);
    chk_reg(2, 1, "R8 tail at 63");
    push(1, 32'hbad0_0001);
    chk_reg(2, 1, "R8 tail held when full");
    chk_reg(3, 1, "R8 overflow set");
    wreg(3, 1, 0);
    chk_reg(3, 1, "R9 overflow sticky");
    wreg(3, 1, 1);
    chk_reg(3, 1, "R9 overflow cleared");

    // R10 wrap
    wreg(1, 1, 63);
    push(1, 32'h3000_0063);
    push(1, 32'h3000_0000);
    chk_reg(2, 1, "R10 tail wrapped");
    chk_ent(1, 63, "R10 entry 63");
    chk_ent(1, 0, "R10 entry 0");
    wreg(1, 1, 32'h47);
    chk_reg(1, 1, "R10 head low bits");

    // R11 collision on a full queue
    wreg(0, 3, 32'h803);
    for (int i = 0; i < 63; i++) push(3, 32'h4000_0000 + i);
    push(3, 32'hbad0_0003, 1, 10);
    chk_reg(2, 3, "R11 tail held");
    chk_reg(1, 3, "R11 head written");
    chk_reg(3, 3, "R11 overflow set");
    chk_irq("R11 irq");

    // random traffic, collisions included
    for (int n = 0; n < 3000; n++) begin
      int g;
      int op;
      g  = $urandom % NG;
      op = $urandom % 8;
      case (op)
        0, 1, 2: push(g, $urandom);
        3: push(g, $urandom, 1, (m_head[g] + ($urandom % (used(g) + 1))) & 63);
        4: wreg(1, g, (m_head[g] + ($urandom % (used(g) + 1))) & 63);
        5: begin
          int c;
          c = $urandom % 5;
          wreg(0, g, (c == 0) ? 32'h801 : (c == 1) ? 32'h0 : 32'h803);
        end
        6: begin
          if (used(g) > 0) chk_ent(g, (m_head[g] + ($urandom % used(g))) & 63, "R3 R4 random entry");
          else chk_reg(2, g, "R3 random tail");
        end
        default: begin
          chk_irq("R5 random irq");
          chk_reg($urandom % 5, g, "R12 random register");
        end
      endcase
    end
    for (int g = 0; g < NG; g++) begin
      chk_reg(2, g, "R3 final tail");
      chk_reg(3, g, "R8 final overflow");
    end
    chk_irq("R5 final irq");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule